// File: doc/BRIEF.md
# Diagnostic Alarm and Warning Flag Generator

This block watches the digitised health monitors of a four-channel optical module and turns them into latched alarm and warning flags for a host. The monitors are module temperature, supply voltage and, for each of four channels, laser bias current, transmit optical power and receive optical power. Every monitored value has four programmable limits: high alarm, low alarm, high warning and low warning. When a value crosses a limit on a sampled update, the matching flag bit latches.

The flags are packed into bytes by source and channel, so one pass over the flag bytes tells the host which quantity, which channel and which severity caused an event. Reading a byte returns its contents and clears the bits whose condition has gone away. An active-low interrupt output goes low while any latched flag is not masked. The sampled monitor values arrive already converted to numbers, and a serial access layer above the read port is assumed.

Top module: `diag_flag_gen`

## Requirements
- R1: After reset every flag byte reads 0x00, `rd_data_o` is 0x00 and `intr_n_o` is 1.
- R2: On a cycle with `sample_i` high, a high-alarm or high-warning bit latches when the value is strictly greater than its limit. Equality does not set it. Supply, bias and power values compare as unsigned.
- R3: On a cycle with `sample_i` high, a low-alarm or low-warning bit latches when the value is strictly less than its limit. Equality does not set it.
- R4: Temperature and its four limits compare as 16-bit two's complement numbers.
- R5: Flag nibble n sits in byte n/2, in bits 3:0 when n is even and bits 7:4 when n is odd. Nibble 0 is temperature, 1 is supply, 2+c is bias of channel c, 6+c is transmit power of channel c and 10+c is receive power of channel c. Inside a nibble, bit 0 is high alarm, bit 1 low alarm, bit 2 high warning and bit 3 low warning. Limits for kind k (0 temperature, 1 supply, 2 bias, 3 transmit, 4 receive) and limit t (same order as the nibble bits) are at `thr_i[(k*4+t)*16 +: 16]`. Bias and power limits are shared by all four channels.
- R6: A latched bit stays set, even after its value returns to range, until its byte is read.
- R7: A read with `rd_en_i` high returns the byte's pre-read contents on `rd_data_o` after the next clock edge. In the same edge the byte's bits take the most recently sampled condition, so a bit whose condition still holds stays set. Addresses 7 and above return 0x00.
- R8: A read changes only the addressed byte.
- R9: `intr_n_o` is low one clock after any latched flag has its mask bit at 0. It returns high one clock after no such flag remains.
- R10: A flag whose bit in `mask_i` (same bit position as the flag) is 1 still latches and reads back, but does not pull `intr_n_o` low.
- R11: The flags of each channel depend only on that channel's own values.
- R12: Monitor changes while `sample_i` is low set no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Monitor values are valid this cycle |
| mon_temp_i | input | 16 | Temperature, two's complement |
| mon_vcc_i | input | 16 | Supply voltage, unsigned |
| mon_bias_i | input | 64 | Laser bias, channel c in bits c*16 +: 16 |
| mon_txp_i | input | 64 | Transmit power, channel c in bits c*16 +: 16 |
| mon_rxp_i | input | 64 | Receive power, channel c in bits c*16 +: 16 |
| thr_i | input | 320 | Limit set, layout given in R5 |
| mask_i | input | 56 | Interrupt mask, one bit per flag bit |
| rd_en_i | input | 1 | Read strobe for one flag byte |
| rd_addr_i | input | 3 | Flag byte index |
| rd_data_o | output | 8 | Pre-read byte contents, registered |
| intr_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `sample_i` and `rd_en_i` are single-cycle strobes sampled at the clock edge. They also assume that the mask and limit buses stay steady between the edges of interest, because the interrupt is checked one clock after the flags that drive it. The stimulus changes every input only on the falling edge. It holds the mask and limits constant while the interrupt is checked, and it issues each read as a one-cycle pulse, so all of these assumptions hold.

// File: rtl/diag_flag_pkg.sv
package diag_flag_pkg;
  localparam int MON_W  = 16;
  localparam int N_LIM  = 4;
  localparam int N_KIND = 5;
  localparam int LIM_HA = 0;
  localparam int LIM_LA = 1;
  localparam int LIM_HW = 2;
  localparam int LIM_LW = 3;
  localparam int LIM_SET_W = N_LIM * MON_W;

  typedef logic [MON_W-1:0] mon_t;
  typedef logic [N_LIM-1:0] nib_t;
  typedef logic [LIM_SET_W-1:0] lim_set_t;

  // Map a value onto an unsigned scale that keeps its order.
  function automatic mon_t to_order(mon_t v, bit sgn);
    return sgn ? {~v[MON_W-1], v[MON_W-2:0]} : v;
  endfunction

  // Four-limit range test; bit order follows the LIM_* indices.
  function automatic nib_t range_check(mon_t v, lim_set_t lim, bit sgn);
    mon_t ov;
    nib_t r;
    ov = to_order(v, sgn);
    r[LIM_HA] = ov > to_order(lim[LIM_HA*MON_W +: MON_W], sgn);
    r[LIM_LA] = ov < to_order(lim[LIM_LA*MON_W +: MON_W], sgn);
    r[LIM_HW] = ov > to_order(lim[LIM_HW*MON_W +: MON_W], sgn);
    r[LIM_LW] = ov < to_order(lim[LIM_LW*MON_W +: MON_W], sgn);
    return r;
  endfunction
endpackage

// File: rtl/diag_cmp.sv
module diag_cmp
  import diag_flag_pkg::*;
#(
  parameter bit SIGNED_V = 1'b0
) (
  input  mon_t     value_i,
  input  lim_set_t lim_i,
  output nib_t     over_o
);
  assign over_o = range_check(value_i, lim_i, SIGNED_V);
endmodule

// File: rtl/diag_flag_bank.sv
module diag_flag_bank #(
  parameter int N_BYTE = 7,
  parameter int AW     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic [N_BYTE*8-1:0] cond_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [N_BYTE*8-1:0] flags_o,
  output logic [7:0]          rd_data_o
);
  localparam int N_BIT = N_BYTE * 8;

  logic [N_BIT-1:0]  cond_q;
  logic [N_BIT-1:0]  flag_q;
  logic [N_BYTE-1:0] rd_hit;
  logic [7:0]        rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else if (sample_i) cond_q <= cond_i;
  end

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    assign rd_hit[b] = rd_en_i && (rd_addr_i == AW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[b*8 +: 8] <= 8'h00;
      else flag_q[b*8 +: 8] <= (rd_hit[b] ? cond_q[b*8 +: 8] : flag_q[b*8 +: 8])
                              | (sample_i ? cond_i[b*8 +: 8] : 8'h00);
    end

    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit[b] |=> ((flag_q[b*8 +: 8] & $past(flag_q[b*8 +: 8])) == $past(flag_q[b*8 +: 8]))); // R6
    AST_CLEAR_KEEPS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit[b] |=> ((flag_q[b*8 +: 8] & $past(cond_q[b*8 +: 8])) == $past(cond_q[b*8 +: 8]))); // R7
  end

  always_comb begin
    rd_sel = 8'h00;
    for (int b = 0; b < N_BYTE; b++)
      if (rd_hit[b]) rd_sel = flag_q[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= 8'h00;
    else if (rd_en_i) rd_data_o <= rd_sel;
  end

  assign flags_o = flag_q;

  AST_SAMPLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> ((flag_q & $past(cond_i)) == $past(cond_i))); // R2
endmodule

// File: rtl/diag_irq.sv
module diag_irq #(
  parameter int N_BIT = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_BIT-1:0] flags_i,
  input  logic [N_BIT-1:0] mask_i,
  output logic             intr_n_o
);
  logic any_live;
  assign any_live = |(flags_i & ~mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intr_n_o <= 1'b1;
    else intr_n_o <= ~any_live;
  end
endmodule

// File: rtl/diag_flag_gen.sv
module diag_flag_gen
  import diag_flag_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int N_NIB  = 2 + 3 * N_CH,
  localparam int N_BYTE = (N_NIB + 1) / 2,
  localparam int N_BIT  = N_BYTE * 8,
  localparam int AW     = $clog2(N_BYTE)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_i,
  input  logic [MON_W-1:0]              mon_temp_i,
  input  logic [MON_W-1:0]              mon_vcc_i,
  input  logic [N_CH*MON_W-1:0]         mon_bias_i,
  input  logic [N_CH*MON_W-1:0]         mon_txp_i,
  input  logic [N_CH*MON_W-1:0]         mon_rxp_i,
  input  logic [N_KIND*LIM_SET_W-1:0]   thr_i,
  input  logic [N_BIT-1:0]              mask_i,
  input  logic                          rd_en_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [7:0]                    rd_data_o,
  output logic                          intr_n_o
);
  mon_t             mon_val [N_NIB];
  logic [N_BIT-1:0] cond_all;
  logic [N_BIT-1:0] flags;

  always_comb begin
    mon_val[0] = mon_temp_i;
    mon_val[1] = mon_vcc_i;
    for (int c = 0; c < N_CH; c++) begin
      mon_val[2 + c]          = mon_bias_i[c*MON_W +: MON_W];
      mon_val[2 + N_CH + c]   = mon_txp_i[c*MON_W +: MON_W];
      mon_val[2 + 2*N_CH + c] = mon_rxp_i[c*MON_W +: MON_W];
    end
  end

  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    localparam int KIND = (n == 0) ? 0 : (n == 1) ? 1 : 2 + (n - 2) / N_CH;
    diag_cmp #(.SIGNED_V(n == 0)) cmp_i (
      .value_i (mon_val[n]),
      .lim_i   (thr_i[KIND*LIM_SET_W +: LIM_SET_W]),
      .over_o  (cond_all[n*N_LIM +: N_LIM])
    );
  end

  if (N_NIB % 2 != 0) begin : g_pad
    assign cond_all[N_BIT-1 -: N_LIM] = '0;
  end

  diag_flag_bank #(.N_BYTE(N_BYTE), .AW(AW)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample_i),
    .cond_i    (cond_all),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .flags_o   (flags),
    .rd_data_o (rd_data_o)
  );

  diag_irq #(.N_BIT(N_BIT)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_i  (flags),
    .mask_i   (mask_i),
    .intr_n_o (intr_n_o)
  );

  AST_INT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~mask_i)) |=> !intr_n_o); // R9
  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~mask_i) == '0) |=> intr_n_o); // R10
  AST_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !rd_en_i) |=> (flags == $past(flags))); // R12
endmodule

// File: tb/diag_flag_gen_tb.sv
module diag_flag_gen_tb_top;
  localparam int NB = 7;
  localparam int NN = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic rd_en = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [55:0] mask = '0;
  logic [15:0] mv [NN];
  logic [15:0] tv [5][4];
  logic [15:0] p_temp, p_vcc;
  logic [63:0] p_bias, p_txp, p_rxp;
  logic [319:0] p_thr;
  logic [7:0] rd_data;
  logic intr_n;

  logic [3:0] m_cond [NN];
  logic [3:0] m_flag [NN];
  logic [7:0] q_exp [$];
  string q_tag [$];
  logic rd_seen = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    p_temp = mv[0];
    p_vcc = mv[1];
    for (int c = 0; c < 4; c++) begin
      p_bias[c*16 +: 16] = mv[2+c];
      p_txp[c*16 +: 16] = mv[6+c];
      p_rxp[c*16 +: 16] = mv[10+c];
    end
    for (int k = 0; k < 5; k++)
      for (int t = 0; t < 4; t++) p_thr[(k*4+t)*16 +: 16] = tv[k][t];
  end

  diag_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample),
    .mon_temp_i(p_temp), .mon_vcc_i(p_vcc), .mon_bias_i(p_bias),
    .mon_txp_i(p_txp), .mon_rxp_i(p_rxp), .thr_i(p_thr), .mask_i(mask),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .intr_n_o(intr_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_nib(int n);
    int k;
    logic [3:0] r;
    k = (n == 0) ? 0 : (n == 1) ? 1 : 2 + (n - 2) / 4;
    if (n == 0) begin
      r[0] = $signed(mv[n]) > $signed(tv[k][0]);
      r[1] = $signed(mv[n]) < $signed(tv[k][1]);
      r[2] = $signed(mv[n]) > $signed(tv[k][2]);
      r[3] = $signed(mv[n]) < $signed(tv[k][3]);
    end else begin
      r[0] = mv[n] > tv[k][0];
      r[1] = mv[n] < tv[k][1];
      r[2] = mv[n] > tv[k][2];
      r[3] = mv[n] < tv[k][3];
    end
    return r;
  endfunction

  function automatic logic model_int();
    logic any;
    any = 1'b0;
    for (int n = 0; n < NN; n++)
      any = any | (|(m_flag[n] & ~mask[n*4 +: 4]));
    return ~any;
  endfunction

  task automatic set_nominal();
    mv[0] = 16'd2500; mv[1] = 16'd3300;
    for (int c = 0; c < 4; c++) begin
      mv[2+c] = 16'd500; mv[6+c] = 16'd2000; mv[10+c] = 16'd2000;
    end
  endtask

  // Driver: one sample strobe, model updated in step.
  task automatic do_sample();
    sample = 1'b1;
    for (int n = 0; n < NN; n++) begin
      m_cond[n] = model_nib(n);
      m_flag[n] = m_flag[n] | m_cond[n];
    end
    @(posedge clk); @(negedge clk);
    sample = 1'b0;
  endtask

  // Driver: one read strobe, expected byte pushed to the scoreboard.
  task automatic do_read(int b, string tag);
    rd_en = 1'b1;
    rd_addr = 3'(b);
    if (b < NB) begin
      q_exp.push_back({m_flag[2*b+1], m_flag[2*b]});
      m_flag[2*b] = m_cond[2*b];
      m_flag[2*b+1] = m_cond[2*b+1];
    end else q_exp.push_back(8'h00);
    q_tag.push_back(tag);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int b = 0; b < NB; b++) do_read(b, tag);
  endtask

  task automatic check_int(string tag);
    @(posedge clk); @(negedge clk);
    chk(tag, {7'd0, intr_n}, {7'd0, model_int()});
  endtask

  // Monitor: compare read data after the edge that captured it.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_exp.size() == 0) chk("scoreboard underflow", 8'h01, 8'h00);
      else chk(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tv[0][0] = 16'd7000; tv[0][1] = 16'hFE0C; tv[0][2] = 16'd6500; tv[0][3] = 16'd0;
    tv[1][0] = 16'd3600; tv[1][1] = 16'd3000; tv[1][2] = 16'd3500; tv[1][3] = 16'd3100;
    tv[2][0] = 16'd1000; tv[2][1] = 16'd100;  tv[2][2] = 16'd900;  tv[2][3] = 16'd200;
    for (int k = 3; k < 5; k++) begin
      tv[k][0] = 16'd5000; tv[k][1] = 16'd500; tv[k][2] = 16'd4500; tv[k][3] = 16'd800;
    end
    set_nominal();
    for (int n = 0; n < NN; n++) begin m_cond[n] = 4'h0; m_flag[n] = 4'h0; end
    repeat (3) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    chk("R1 intr after reset", {7'd0, intr_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 flag bytes after reset");

    do_sample();
    read_all("R2 R3 nominal values set nothing");
    check_int("R9 intr high with no flags");

    // Supply above the high warning only: byte 0 bits 7:4 = 0x4.
    mv[1] = 16'd3550;
    do_sample();
    check_int("R9 intr low on unmasked flag");
    mv[1] = 16'd3300;
    do_sample();
    do_read(0, "R6 R5 supply warning stays latched");
    do_read(0, "R7 cleared once condition gone");
    check_int("R9 intr high after clear");

    // Equality boundaries on bias channel 1 and 2.
    mv[3] = 16'd1000; mv[4] = 16'd100;
    do_sample();
    do_read(1, "R2 equal to high alarm sets only warning");
    do_read(2, "R3 equal to low alarm sets only warning");

    // Negative temperature below both low limits.
    mv[0] = 16'hFDA8;
    do_sample();
    do_read(0, "R4 signed temperature low flags");
    do_read(0, "R7 flags remain while condition holds");
    read_all("R8 other bytes untouched by earlier reads");

    // Receive channel 3 above both high limits.
    set_nominal();
    mv[13] = 16'd6000;
    do_sample();
    read_all("R11 R5 only channel 3 receive flags");
    read_all("R7 second pass clears stale bits");

    // Masked flags latch but leave the interrupt high.
    set_nominal();
    do_sample();
    read_all("R7 clear before mask test");
    mask[55:52] = 4'hF;
    mv[13] = 16'd6000;
    do_sample();
    check_int("R10 masked flag keeps intr high");
    mv[2] = 16'd50;
    do_sample();
    check_int("R10 unmasked flag still pulls intr low");
    set_nominal();
    do_sample();
    read_all("R10 masked flag still reads back");
    check_int("R9 intr high after all cleared");
    mask = '0;

    // Monitor values out of range without a sample strobe.
    mv[1] = 16'd4000; mv[7] = 16'd9000; mv[0] = 16'h8000;
    repeat (4) @(negedge clk);
    check_int("R12 no strobe keeps intr high");
    read_all("R12 no strobe sets no flags");
    do_read(7, "R7 out of range address reads zero");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(q_exp.size()), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule